// File: doc/BRIEF.md
# Delayed-Branch Fetch Front End

This block is the fetch and branch-resolution stage of a five-stage load/store pipeline whose instruction set has exactly one branch delay slot. It owns the instruction address register and drives it straight onto a dedicated instruction-memory read port. The port is separate from the data side, so fetch never waits on loads or stores. Each fetched word, together with its own address, is registered into the decode stage with a valid bit.

The decode stage sends back a branch flag, a signed word offset and two register operand values. When the flag is set and the operands are equal, the branch is taken. The target is the branch's own address plus the offset scaled to bytes. The word after the branch is already being fetched at that point, so it is always delivered to decode, and the target is fetched in the following cycle. Nothing is ever squashed.

A stall input freezes the fetch address and the decode register. Any branch decision made while stalled is captured and applied when the stall lifts. A branch placed in another branch's delay slot is ignored, so the first branch's target stands and the unit keeps running. Reset is synchronous and active low.

Top module: `dslot_fetch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the fetch address becomes `RESET_VEC` and `id_valid_o` becomes 0.
- R2: With no stall and no taken branch, the fetch address advances by 4 each cycle. In the next cycle, decode holds the fetched word, its address and `id_valid_o`=1.
- R3: If decode holds a valid branch (`br_flag_i`=1) and `br_ra_i`==`br_rb_i`, the fetch address in the next cycle is the branch address plus `br_off_i` (signed, in words) times 4.
- R4: If the branch operands differ, fetching continues at sequential addresses.
- R5: The word at branch address + 4 (the delay slot) reaches decode with `id_valid_o`=1 whether the branch is taken or not.
- R6: While `stall_i` is high, the fetch address and the decode outputs keep their values.
- R7: A branch decision made in the first stalled cycle of a branch is kept. Operand changes later in the stall have no effect, and the decision steers fetch on the first cycle after the stall.
- R8: A branch flag raised for the delay-slot instruction is ignored, so fetch goes to the first branch's target.
- R9: `br_flag_i` is ignored while `id_valid_o` is 0.
- R10: Negative offsets are sign-extended, so backward branches reach lower addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and decode registers |
| imem_addr_o | output | AW | Instruction memory read address |
| imem_data_i | input | IW | Instruction word read at `imem_addr_o` (same cycle) |
| br_flag_i | input | 1 | Decode-stage instruction is a conditional branch |
| br_off_i | input | OFFW | Signed word offset of the branch |
| br_ra_i | input | DW | First compared operand |
| br_rb_i | input | DW | Second compared operand |
| id_instr_o | output | IW | Instruction held in decode |
| id_pc_o | output | AW | Address of the instruction in decode |
| id_valid_o | output | 1 | Decode instruction is valid |

## Verification
The bench builds the block with a 32-bit address, a 12-bit offset field and a reset vector of 0x100. A non-zero vector separates real fetch addresses from the zeroed decode address left by reset, which exposes any use of an invalid decode entry as a branch. The narrow offset places the sign bit at bit 11, so a backward branch exercises the sign extension. A small offset can express both forward and backward targets within a few words of the vector.

// File: rtl/dsf_pkg.sv
// Package: shared constants for the delayed-branch fetch front end.
// Assumes fixed-width instructions of four bytes.
package dsf_pkg;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned BYTE_SHIFT  = 2;

    // Holds the decision captured while the pipeline is stalled.
    typedef struct packed {
        logic vld;
        logic take;
    } pend_flags_t;
endpackage

// File: rtl/dsf_next_addr.sv
// Module: dsf_next_addr
// Forms the sequential address and the branch target, and compares the two
// branch operands. Assumes AW > OFFW + BYTE_SHIFT.
module dsf_next_addr #(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned OFFW = 16
) (
    input  logic [AW-1:0]   fetch_pc,
    input  logic [AW-1:0]   dec_pc,
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [AW-1:0]   seq_addr,
    output logic [AW-1:0]   tgt_addr,
    output logic            ops_equal
);
    import dsf_pkg::*;

    localparam int unsigned EXTW = AW - OFFW;

    logic [AW-1:0] off_bytes;

    // Sign-extend the word offset and scale it to bytes.
    always_comb begin
        off_bytes = {{EXTW{off[OFFW-1]}}, off} << BYTE_SHIFT;
    end

    // Compute both candidate addresses and the equality condition.
    always_comb begin
        seq_addr  = fetch_pc + AW'(INSTR_BYTES);
        tgt_addr  = dec_pc + off_bytes;
        ops_equal = (opa == opb);
    end
endmodule

// File: rtl/dsf_branch_ctrl.sv
// Module: dsf_branch_ctrl
// Decides whether fetch is redirected. Tracks the delay slot so that a
// branch in the slot is ignored. Holds a decision taken while stalled until
// the stall ends. Assumes br_live is already qualified by decode valid.
module dsf_branch_ctrl #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          br_live,
    input  logic          ops_equal,
    input  logic [AW-1:0] tgt_addr,
    output logic          redirect,
    output logic [AW-1:0] redir_addr,
    output logic          in_slot
);
    import dsf_pkg::*;

    pend_flags_t   pend_q;
    logic [AW-1:0] pend_tgt_q;
    logic          slot_q;
    logic          br_eff;
    logic          take_live;

    // Qualify the live branch: a branch sitting in a delay slot is dropped.
    always_comb begin
        br_eff    = br_live && !slot_q;
        take_live = br_eff && ops_equal;
    end

    // Choose between the held decision and the live decision.
    always_comb begin
        redirect   = !stall && (pend_q.vld ? pend_q.take : take_live);
        redir_addr = pend_q.vld ? pend_tgt_q : tgt_addr;
        in_slot    = slot_q;
    end

    // Capture a decision during a stall and track the delay slot on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_tgt_q <= '0;
            slot_q     <= 1'b0;
        end else if (stall) begin
            if (!pend_q.vld && br_eff) begin
                pend_q.vld  <= 1'b1;
                pend_q.take <= ops_equal;
                pend_tgt_q  <= tgt_addr;
            end
        end else begin
            pend_q <= '0;
            slot_q <= pend_q.vld || br_eff;
        end
    end

    AST_PEND_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q.vld && !stall) |=> !pend_q.vld); // R7

    AST_HELD_DECISION_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q.vld && stall) |=> (pend_tgt_q == $past(pend_tgt_q))); // R7
endmodule

// File: rtl/dsf_id_reg.sv
// Module: dsf_id_reg
// Pipeline register between fetch and decode. Assumes the instruction word
// arrives in the same cycle its address is presented.
module dsf_id_reg #(
    parameter int unsigned AW = 32,
    parameter int unsigned IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [IW-1:0] f_instr,
    input  logic [AW-1:0] f_pc,
    output logic [IW-1:0] d_instr,
    output logic [AW-1:0] d_pc,
    output logic          d_valid
);
    // Load the fetched word each cycle that is not stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_instr <= '0;
            d_pc    <= '0;
            d_valid <= 1'b0;
        end else if (!stall) begin
            d_instr <= f_instr;
            d_pc    <= f_pc;
            d_valid <= 1'b1;
        end
    end

    AST_DECODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(d_instr) && $stable(d_pc) && $stable(d_valid))); // R6
endmodule

// File: rtl/dslot_fetch.sv
// Module: dslot_fetch (top)
// Fetch front end with one architectural branch delay slot. Holds the
// instruction address register and drives it onto a private instruction
// port. Resolves equality branches from decode. The delay-slot word is
// always passed on. Assumes a combinational instruction read.
module dslot_fetch #(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned IW        = 32,
    parameter int unsigned OFFW      = 16,
    parameter logic [AW-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    output logic [AW-1:0]   imem_addr_o,
    input  logic [IW-1:0]   imem_data_i,
    input  logic            br_flag_i,
    input  logic [OFFW-1:0] br_off_i,
    input  logic [DW-1:0]   br_ra_i,
    input  logic [DW-1:0]   br_rb_i,
    output logic [IW-1:0]   id_instr_o,
    output logic [AW-1:0]   id_pc_o,
    output logic            id_valid_o
);
    logic [AW-1:0] pc_q;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] redir_addr;
    logic          ops_equal;
    logic          redirect;
    logic          in_slot;
    logic          br_live;

    // A branch counts only when decode holds a valid instruction.
    always_comb begin
        br_live     = br_flag_i && id_valid_o;
        imem_addr_o = pc_q;
    end

    dsf_next_addr #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_next (
        .fetch_pc  (pc_q),
        .dec_pc    (id_pc_o),
        .off       (br_off_i),
        .opa       (br_ra_i),
        .opb       (br_rb_i),
        .seq_addr  (seq_addr),
        .tgt_addr  (tgt_addr),
        .ops_equal (ops_equal)
    );

    dsf_branch_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall_i),
        .br_live    (br_live),
        .ops_equal  (ops_equal),
        .tgt_addr   (tgt_addr),
        .redirect   (redirect),
        .redir_addr (redir_addr),
        .in_slot    (in_slot)
    );

    dsf_id_reg #(.AW(AW), .IW(IW)) u_idr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall_i),
        .f_instr (imem_data_i),
        .f_pc    (pc_q),
        .d_instr (id_instr_o),
        .d_pc    (id_pc_o),
        .d_valid (id_valid_o)
    );

    // Instruction address register: hold, redirect, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_VEC;
        else if (!stall_i)
            pc_q <= redirect ? redir_addr : seq_addr;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !redirect) |=> (imem_addr_o == $past(imem_addr_o) + AW'(4))); // R2

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (imem_addr_o == $past(redir_addr))); // R3

    AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(imem_addr_o)); // R6

    AST_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_live && !stall_i) |=> id_valid_o); // R5

    AST_SLOT_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && !stall_i && !$past(stall_i)) |-> !$past(redirect) || !redirect); // R8
endmodule

// File: tb/dslot_fetch_bench.sv
module dslot_fetch_bench;
    localparam int unsigned AW   = 32;
    localparam int unsigned OFFW = 12;
    localparam logic [31:0] RV   = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [31:0] imem_addr_o, imem_data_i, id_instr_o, id_pc_o;
    logic        id_valid_o, br_flag_i;
    logic [OFFW-1:0] br_off_i;
    logic [31:0] br_ra_i, br_rb_i;

    // Scenario configuration
    logic        br_en = 1'b0, br2_en = 1'b0, force_flag = 1'b0;
    logic [31:0] br_at = '0, br2_at = '0;
    logic [OFFW-1:0] off1 = '0, off2 = '0;
    logic [31:0] opa = '0, opb = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] code(input logic [31:0] a);
        return a ^ 32'h5A00_0000;
    endfunction

    assign imem_data_i = code(imem_addr_o);
    assign br_flag_i   = force_flag ||
                         (id_valid_o && ((br_en && id_pc_o == br_at) || (br2_en && id_pc_o == br2_at)));
    assign br_off_i    = (br2_en && id_pc_o == br2_at) ? off2 : off1;
    assign br_ra_i     = opa;
    assign br_rb_i     = opb;

    dslot_fetch #(.AW(AW), .DW(32), .IW(32), .OFFW(OFFW), .RESET_VEC(RV)) u_dslot_fetch (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
        .br_flag_i(br_flag_i), .br_off_i(br_off_i), .br_ra_i(br_ra_i), .br_rb_i(br_rb_i),
        .id_instr_o(id_instr_o), .id_pc_o(id_pc_o), .id_valid_o(id_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic expect_id(input string tag, input logic [31:0] pc);
        @(negedge clk);
        chk({tag, " decode pc"}, id_pc_o, pc);
        chk({tag, " decode valid"}, {31'd0, id_valid_o}, 32'd1);
        chk({tag, " decode word"}, id_instr_o, code(pc));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stall_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 fetch at reset vector", imem_addr_o, RV);
        chk("R1 decode invalid", {31'd0, id_valid_o}, 32'd0);
    endtask

    task automatic clear_cfg();
        br_en = 0; br2_en = 0; force_flag = 0;
        br_at = '0; br2_at = '0; off1 = '0; off2 = '0; opa = '0; opb = '0;
    endtask

    task automatic t_seq();
        clear_cfg();
        do_reset();
        expect_id("R2 seq", 32'h100);
        chk("R2 next fetch", imem_addr_o, 32'h104);
        expect_id("R2 seq", 32'h104);
        expect_id("R2 seq", 32'h108);
        expect_id("R2 seq", 32'h10C);
    endtask

    task automatic t_taken();
        clear_cfg();
        br_en = 1; br_at = 32'h108; off1 = 12'd8; opa = 5; opb = 5;
        do_reset();
        expect_id("R3 pre", 32'h100);
        expect_id("R3 pre", 32'h104);
        expect_id("R3 branch", 32'h108);
        chk("R5 slot being fetched", imem_addr_o, 32'h10C);
        expect_id("R5 slot taken", 32'h10C);
        chk("R3 target fetch", imem_addr_o, 32'h128);
        expect_id("R3 target", 32'h128);
        expect_id("R3 after target", 32'h12C);
    endtask

    task automatic t_not_taken();
        clear_cfg();
        br_en = 1; br_at = 32'h108; off1 = 12'd8; opa = 5; opb = 6;
        do_reset();
        expect_id("R4 pre", 32'h100);
        expect_id("R4 pre", 32'h104);
        expect_id("R4 branch", 32'h108);
        expect_id("R5 slot not taken", 32'h10C);
        expect_id("R4 fall through", 32'h110);
    endtask

    task automatic t_backward();
        clear_cfg();
        br_en = 1; br_at = 32'h108; off1 = 12'hFFE; opa = 3; opb = 3;
        do_reset();
        expect_id("R10 pre", 32'h100);
        expect_id("R10 pre", 32'h104);
        expect_id("R10 branch", 32'h108);
        expect_id("R10 slot", 32'h10C);
        expect_id("R10 backward target", 32'h100);
        expect_id("R10 after target", 32'h104);
    endtask

    task automatic t_stall();
        clear_cfg();
        br_en = 1; br_at = 32'h108; off1 = 12'd8; opa = 7; opb = 7;
        do_reset();
        expect_id("R6 pre", 32'h100);
        expect_id("R6 pre", 32'h104);
        expect_id("R6 branch", 32'h108);
        stall_i = 1'b1;
        @(negedge clk);
        chk("R6 decode held", id_pc_o, 32'h108);
        chk("R6 fetch held", imem_addr_o, 32'h10C);
        opb = 9;
        @(negedge clk);
        chk("R6 decode held 2", id_pc_o, 32'h108);
        chk("R6 fetch held 2", imem_addr_o, 32'h10C);
        @(negedge clk);
        chk("R6 decode word held", id_instr_o, code(32'h108));
        stall_i = 1'b0;
        expect_id("R7 slot after stall", 32'h10C);
        chk("R7 held decision redirects", imem_addr_o, 32'h128);
        expect_id("R7 target", 32'h128);
    endtask

    task automatic t_slot_branch();
        clear_cfg();
        br_en = 1; br_at = 32'h108; off1 = 12'd8;
        br2_en = 1; br2_at = 32'h10C; off2 = 12'hFFC;
        opa = 1; opb = 1;
        do_reset();
        expect_id("R8 pre", 32'h100);
        expect_id("R8 pre", 32'h104);
        expect_id("R8 first branch", 32'h108);
        expect_id("R8 slot branch", 32'h10C);
        expect_id("R8 first target wins", 32'h128);
        expect_id("R8 continues", 32'h12C);
    endtask

    task automatic t_invalid_flag();
        clear_cfg();
        force_flag = 1; off1 = 12'd8; opa = 2; opb = 2;
        do_reset();
        @(negedge clk);
        chk("R9 flag ignored while invalid", imem_addr_o, 32'h104);
        chk("R9 first word", id_pc_o, 32'h100);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_seq();
        t_taken();
        t_not_taken();
        t_backward();
        t_stall();
        t_slot_branch();
        t_invalid_flag();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule